// File: doc/BRIEF.md
# USB Host OUT Packet Transmit Queue

This block sits on the transmit side of a full-speed USB host channel. A driver loads a transfer length and a maximum packet size, then writes the payload as 32-bit words. The block splits the transfer into packets. Each packet is the maximum packet size, except the last one, which holds whatever bytes remain. When the word that completes a packet is accepted, a request entry is queued in that same cycle. The entry carries the channel number and the true byte count. The driver never marks where a packet ends.

A downstream transaction engine takes one request entry at a time and then reads that packet's data words in order. Words of a packet that is not yet complete stay hidden from it. The driver can see the free FIFO words and the free request slots. Before writing, it checks that one whole packet and one request slot fit. If they do not, it waits for the empty interrupt. A halt drops any half-written packet. A separate trigger queues a zero-length packet.

Top module: `hst_tx_pktq`

## Requirements
- R1: After reset, `fifo_free` equals FIFO_DEPTH, `queue_free` equals QUEUE_DEPTH, `empty_irq` is 1, and `req_valid`, `dat_valid`, `ovf_err` and `xfer_rem` are all 0.
- R2: A packet's words become visible to the consumer only once the packet is complete. `req_valid` and `dat_valid` rise in the cycle after the completing word is accepted, not earlier.
- R3: Some writes are rejected and set `ovf_err`: a word written while the FIFO holds FIFO_DEPTH words, a packet-completing word written while the queue holds QUEUE_DEPTH entries, and a zero-length trigger while the queue is full. `ovf_err` stays set until the next `xfer_load`.
- R4: A packet of B bytes takes ceil(B/4) words. Its request entry reports B in `req_bytes`, without the padding bytes (for example, 10 bytes use 3 words and report 10).
- R5: A packet's size is min(`cfg_mps`, `xfer_rem`). Each completed packet lowers `xfer_rem` by that size. A word written while `xfer_rem` is 0 is discarded and sets `ovf_err`.
- R6: `fifo_free` equals FIFO_DEPTH minus every stored word, whether committed or partial. `queue_free` equals QUEUE_DEPTH minus the queued entries.
- R7: `empty_irq` is 1 exactly when the FIFO holds no words.
- R8: `dat_word` presents words in write order. A `dat_pop` or `req_pop` while the matching valid is 0 changes nothing.
- R9: `halt` discards the words of an unfinished packet and sets `xfer_rem` to 0. Queued requests and their data are kept. `halt` or `xfer_load` outranks a write in the same cycle.
- R10: When `xfer_rem` is 0 and the queue has room, `zlp_trig` queues an entry with byte count 0 and no data words. When `xfer_rem` is nonzero, `zlp_trig` is ignored.
- R11: The channel number in a request entry is the value of `cfg_chan` in the cycle the entry is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_chan | input | CHAN_W | Channel number stamped into queued entries |
| cfg_mps | input | BCNT_W | Maximum packet size in bytes, nonzero |
| cfg_xfer_len | input | XFER_W | Transfer length, taken on `xfer_load` |
| xfer_load | input | 1 | Starts a transfer; clears the partial packet and `ovf_err` |
| halt | input | 1 | Drops the partial packet and ends the transfer |
| wr_valid | input | 1 | Word write strobe |
| wr_data | input | 32 | Word to write |
| zlp_trig | input | 1 | Queues a zero-length packet request |
| fifo_free | output | CNT_W | Free FIFO words |
| queue_free | output | QCNT_W | Free request slots |
| empty_irq | output | 1 | FIFO holds no words |
| ovf_err | output | 1 | Sticky rejected-write flag |
| xfer_rem | output | XFER_W | Bytes of the transfer not yet packetised |
| req_valid | output | 1 | Request entry available |
| req_chan | output | CHAN_W | Channel of the head entry |
| req_bytes | output | BCNT_W | Byte count of the head entry |
| req_pop | input | 1 | Removes the head entry |
| dat_valid | output | 1 | Committed data word available |
| dat_word | output | 32 | Head data word |
| dat_pop | input | 1 | Removes the head data word |

## Verification
On every cycle, the assertions check a set of invariants. The FIFO occupancy always splits exactly into committed words and partial words. The error flag stays set until a new load. The remaining byte count never rises except on a load. A halt leaves no partial words behind. Committed data only appears right after a request push. `empty_irq` agrees with the free-word count. Checking that packet sizing, padding, channel stamps and word order come out right needs the bench's reference model and its scenarios: odd lengths, a full FIFO, a full queue, a halt in mid-packet, zero-length triggers, and mixed random writes and pops.

// File: rtl/hst_txq_pkg.sv
// Shared widths and the request entry layout for the host transmit queue.
package hst_txq_pkg;
    localparam int CHAN_W = 4;   // channel number width
    localparam int BCNT_W = 11;  // packet byte count width

    // One queued OUT request: channel and true byte count (no padding).
    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [BCNT_W-1:0] bytes;
    } txq_req_t;
endpackage

// File: rtl/hst_txq_ring.sv
// Circular store with push, pop and a tail rewind.
// Assumes: the caller never pushes and rewinds in the same cycle, never
// pops when empty, never pushes when full, and the rewind amount is not
// larger than the number of stored entries.
module hst_txq_ring #(
    parameter int W      = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    input  logic             drop_en,
    input  logic [CNT_W-1:0] drop_n,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;

    // Next pointers: wrap on increment; step back by drop_n on a rewind.
    always_comb begin
        int back;
        back       = int'(wr_ptr) - int'(drop_n);
        if (back < 0) back = back + DEPTH;
        if (drop_en)
            wr_ptr_nxt = PTR_W'(back);
        else if (push)
            wr_ptr_nxt = (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
        else
            wr_ptr_nxt = wr_ptr;
        if (pop)
            rd_ptr_nxt = (int'(rd_ptr) == DEPTH - 1) ? '0 : rd_ptr + 1'b1;
        else
            rd_ptr_nxt = rd_ptr;
    end

    // Storage write: data enters at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr_nxt;
            rd_ptr <= rd_ptr_nxt;
            count  <= CNT_W'(int'(count) + int'(push) - int'(pop)
                             - (drop_en ? int'(drop_n) : 0));
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/hst_txq_pktgen.sv
// Packet boundary tracker. It works out the current packet size from the
// remaining transfer bytes and the maximum packet size, counts the words of
// the partial packet, commits them with a request push on the completing
// word, rejects writes that cannot fit, and handles halt, load and
// zero-length triggers.
// Assumes: cfg_mps is nonzero, XFER_W >= BCNT_W, and one packet's words
// fit in FIFO_DEPTH.
module hst_txq_pktgen #(
    parameter int FIFO_DEPTH  = 16,
    parameter int QUEUE_DEPTH = 4,
    parameter int XFER_W      = 19,
    parameter int BCNT_W      = 11,
    parameter int CNT_W       = $clog2(FIFO_DEPTH + 1),
    parameter int QCNT_W      = $clog2(QUEUE_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BCNT_W-1:0] cfg_mps,
    input  logic [XFER_W-1:0] cfg_len,
    input  logic              xfer_load,
    input  logic              halt,
    input  logic              wr_valid,
    input  logic              zlp_trig,
    input  logic              dat_pop,
    input  logic [CNT_W-1:0]  fifo_cnt,
    input  logic [QCNT_W-1:0] q_cnt,
    output logic              wr_take,
    output logic              dat_take,
    output logic              req_push,
    output logic [BCNT_W-1:0] req_bytes,
    output logic              drop_en,
    output logic [CNT_W-1:0]  drop_n,
    output logic [CNT_W-1:0]  commit_cnt,
    output logic [CNT_W-1:0]  part_cnt,
    output logic [XFER_W-1:0] xfer_rem,
    output logic              ovf_err
);
    logic [BCNT_W-1:0] pkt_bytes;
    logic flush, fifo_full, q_full, completes, wr_bad, zlp_ok, zlp_bad, pkt_done;

    // Current packet size, fullness and the accept/reject decisions.
    always_comb begin
        int need;
        pkt_bytes = (xfer_rem < XFER_W'(cfg_mps)) ? BCNT_W'(xfer_rem) : cfg_mps;
        need      = (int'(pkt_bytes) + 3) / 4;
        flush     = halt || xfer_load;
        fifo_full = (int'(fifo_cnt) == FIFO_DEPTH);
        q_full    = (int'(q_cnt) == QUEUE_DEPTH);
        completes = (int'(part_cnt) + 1 == need);
        wr_take   = wr_valid && !flush && (xfer_rem != '0) && !fifo_full
                    && !(completes && q_full);
        wr_bad    = wr_valid && !flush && !wr_take;
        zlp_ok    = zlp_trig && !flush && (xfer_rem == '0) && !q_full;
        zlp_bad   = zlp_trig && !flush && (xfer_rem == '0) && q_full;
        pkt_done  = wr_take && completes;
    end

    assign req_push  = pkt_done || zlp_ok;
    assign req_bytes = zlp_ok ? '0 : pkt_bytes;
    assign drop_en   = flush;
    assign drop_n    = part_cnt;
    assign dat_take  = dat_pop && (commit_cnt != '0);

    // Partial and committed word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_cnt   <= '0;
            commit_cnt <= '0;
        end else begin
            if (flush)        part_cnt <= '0;
            else if (wr_take) part_cnt <= completes ? '0 : part_cnt + 1'b1;
            commit_cnt <= CNT_W'(int'(commit_cnt)
                                 + (pkt_done ? int'(part_cnt) + 1 : 0)
                                 - int'(dat_take));
        end
    end

    // Remaining transfer bytes and the sticky rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_rem <= '0;
            ovf_err  <= 1'b0;
        end else begin
            if (xfer_load)     xfer_rem <= cfg_len;
            else if (halt)     xfer_rem <= '0;
            else if (pkt_done) xfer_rem <= xfer_rem - XFER_W'(pkt_bytes);
            if (xfer_load)              ovf_err <= 1'b0;
            else if (wr_bad || zlp_bad) ovf_err <= 1'b1;
        end
    end
endmodule

// File: rtl/hst_tx_pktq.sv
// Top of the host transmit queue: a word data ring, a request ring and the
// packet tracker. The consumer pops one request, then reads exactly
// ceil(bytes/4) data words.
// Assumes: the configuration inputs are stable while a transfer runs.
module hst_tx_pktq
    import hst_txq_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int QUEUE_DEPTH = 4,
    parameter int XFER_W      = 19,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1),
    localparam int QCNT_W     = $clog2(QUEUE_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [BCNT_W-1:0] cfg_mps,
    input  logic [XFER_W-1:0] cfg_xfer_len,
    input  logic              xfer_load,
    input  logic              halt,
    input  logic              wr_valid,
    input  logic [31:0]       wr_data,
    input  logic              zlp_trig,
    output logic [CNT_W-1:0]  fifo_free,
    output logic [QCNT_W-1:0] queue_free,
    output logic              empty_irq,
    output logic              ovf_err,
    output logic [XFER_W-1:0] xfer_rem,
    output logic              req_valid,
    output logic [CHAN_W-1:0] req_chan,
    output logic [BCNT_W-1:0] req_bytes,
    input  logic              req_pop,
    output logic              dat_valid,
    output logic [31:0]       dat_word,
    input  logic              dat_pop
);
    localparam int REQ_W = $bits(txq_req_t);

    logic              wr_take, dat_take, req_push, drop_en;
    logic [CNT_W-1:0]  drop_n, commit_cnt, part_cnt, fifo_cnt;
    logic [QCNT_W-1:0] q_cnt;
    logic [BCNT_W-1:0] push_bytes;
    txq_req_t          push_req, head_req;
    logic [REQ_W-1:0]  head_raw;

    hst_txq_pktgen #(
        .FIFO_DEPTH(FIFO_DEPTH), .QUEUE_DEPTH(QUEUE_DEPTH),
        .XFER_W(XFER_W), .BCNT_W(BCNT_W)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .cfg_mps(cfg_mps), .cfg_len(cfg_xfer_len),
        .xfer_load(xfer_load), .halt(halt), .wr_valid(wr_valid),
        .zlp_trig(zlp_trig), .dat_pop(dat_pop), .fifo_cnt(fifo_cnt),
        .q_cnt(q_cnt), .wr_take(wr_take), .dat_take(dat_take),
        .req_push(req_push), .req_bytes(push_bytes), .drop_en(drop_en),
        .drop_n(drop_n), .commit_cnt(commit_cnt), .part_cnt(part_cnt),
        .xfer_rem(xfer_rem), .ovf_err(ovf_err)
    );

    hst_txq_ring #(.W(32), .DEPTH(FIFO_DEPTH)) u_data (
        .clk(clk), .rst_n(rst_n), .push(wr_take), .push_data(wr_data),
        .pop(dat_take), .drop_en(drop_en), .drop_n(drop_n),
        .head(dat_word), .count(fifo_cnt)
    );

    assign push_req.chan  = cfg_chan;
    assign push_req.bytes = push_bytes;

    hst_txq_ring #(.W(REQ_W), .DEPTH(QUEUE_DEPTH)) u_reqs (
        .clk(clk), .rst_n(rst_n), .push(req_push), .push_data(push_req),
        .pop(req_pop && req_valid), .drop_en(1'b0), .drop_n('0),
        .head(head_raw), .count(q_cnt)
    );

    assign head_req   = head_raw;
    assign req_valid  = (q_cnt != '0);
    assign req_chan   = head_req.chan;
    assign req_bytes  = head_req.bytes;
    assign dat_valid  = (commit_cnt != '0);
    assign fifo_free  = CNT_W'(FIFO_DEPTH - int'(fifo_cnt));
    assign queue_free = QCNT_W'(QUEUE_DEPTH - int'(q_cnt));
    assign empty_irq  = (fifo_cnt == '0);
endmodule

// File: rtl/hst_tx_pktq_chk.sv
// Checker bound to hst_tx_pktq: cycle invariants between the tracker, the
// data ring and the status outputs.
module hst_tx_pktq_chk #(
    parameter int FIFO_DEPTH  = 16,
    parameter int QUEUE_DEPTH = 4,
    parameter int XFER_W      = 19,
    parameter int CNT_W       = 5,
    parameter int QCNT_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_load,
    input logic              halt,
    input logic              ovf_err,
    input logic [XFER_W-1:0] xfer_rem,
    input logic              empty_irq,
    input logic [CNT_W-1:0]  fifo_free,
    input logic [QCNT_W-1:0] queue_free,
    input logic              dat_valid,
    input logic              req_push,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic [CNT_W-1:0]  commit_cnt,
    input logic [CNT_W-1:0]  part_cnt
);
    p_occupancy_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) == int'(commit_cnt) + int'(part_cnt));

    p_queue_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(queue_free) <= QUEUE_DEPTH);

    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err && !xfer_load |=> ovf_err);

    p_partial_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_valid) |-> $past(req_push));

    p_empty_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty_irq |-> int'(fifo_free) == FIFO_DEPTH);

    p_empty_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_irq |-> int'(fifo_free) < FIFO_DEPTH);

    p_rem_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_load |=> xfer_rem <= $past(xfer_rem));

    p_halt_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !xfer_load |=> (xfer_rem == '0) && (part_cnt == '0));
endmodule

bind hst_tx_pktq hst_tx_pktq_chk #(
    .FIFO_DEPTH(FIFO_DEPTH), .QUEUE_DEPTH(QUEUE_DEPTH), .XFER_W(XFER_W),
    .CNT_W(CNT_W), .QCNT_W(QCNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_load(xfer_load), .halt(halt),
    .ovf_err(ovf_err), .xfer_rem(xfer_rem), .empty_irq(empty_irq),
    .fifo_free(fifo_free), .queue_free(queue_free), .dat_valid(dat_valid),
    .req_push(req_push), .fifo_cnt(fifo_cnt), .commit_cnt(commit_cnt),
    .part_cnt(part_cnt)
);

// File: tb/test_hst_tx_pktq.sv
// Bench: behavioural reference model (queues), compared on every cycle.
module test_hst_tx_pktq;
    localparam int FD = 16;
    localparam int QD = 4;
    localparam int XW = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_chan = '0;
    logic [10:0] cfg_mps = 11'd8;
    logic [XW-1:0] cfg_xfer_len = '0;
    logic        xfer_load = 0, halt = 0, wr_valid = 0, zlp_trig = 0;
    logic        req_pop = 0, dat_pop = 0;
    logic [31:0] wr_data = '0;
    logic [4:0]  fifo_free;
    logic [2:0]  queue_free;
    logic        empty_irq, ovf_err, req_valid, dat_valid;
    logic [XW-1:0] xfer_rem;
    logic [3:0]  req_chan;
    logic [10:0] req_bytes;
    logic [31:0] dat_word;

    int checks = 0, fails = 0;
    bit finished = 0;

    // reference model state
    int m_dat[$], m_part[$], m_rb[$], m_rc[$];
    int m_rem = 0;
    bit m_err = 0;
    int wcount = 1;

    always #2.5 clk = ~clk;

    hst_tx_pktq i_hst_tx_pktq (
        .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan), .cfg_mps(cfg_mps),
        .cfg_xfer_len(cfg_xfer_len), .xfer_load(xfer_load), .halt(halt),
        .wr_valid(wr_valid), .wr_data(wr_data), .zlp_trig(zlp_trig),
        .fifo_free(fifo_free), .queue_free(queue_free), .empty_irq(empty_irq),
        .ovf_err(ovf_err), .xfer_rem(xfer_rem), .req_valid(req_valid),
        .req_chan(req_chan), .req_bytes(req_bytes), .req_pop(req_pop),
        .dat_valid(dat_valid), .dat_word(dat_word), .dat_pop(dat_pop)
    );

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int tot;
        tot = m_dat.size() + m_part.size();
        chk(int'(fifo_free), FD - tot, "R6", "fifo_free");
        chk(int'(queue_free), QD - m_rb.size(), "R6", "queue_free");
        chk(int'(empty_irq), int'(tot == 0), "R7", "empty_irq");
        chk(int'(req_valid), int'(m_rb.size() > 0), "R2", "req_valid");
        if (m_rb.size() > 0) begin
            chk(int'(req_bytes), m_rb[0], "R4", "req_bytes");
            chk(int'(req_chan), m_rc[0], "R11", "req_chan");
        end
        chk(int'(dat_valid), int'(m_dat.size() > 0), "R2", "dat_valid");
        if (m_dat.size() > 0) chk(int'(dat_word), m_dat[0], "R8", "dat_word");
        chk(int'(ovf_err), int'(m_err), "R3", "ovf_err");
        chk(int'(xfer_rem), m_rem, "R5", "xfer_rem");
    endtask

    // One cycle: model the edge from the current inputs, clock, compare.
    task automatic step();
        int tot, qn, cn, pkt, need, rem0;
        bit comp;
        tot  = m_dat.size() + m_part.size();
        qn   = m_rb.size();
        cn   = m_dat.size();
        rem0 = m_rem;
        pkt  = (m_rem < int'(cfg_mps)) ? m_rem : int'(cfg_mps);
        need = (pkt + 3) / 4;
        comp = (m_part.size() + 1 == need);
        if (dat_pop && cn > 0) void'(m_dat.pop_front());
        if (req_pop && qn > 0) begin
            void'(m_rb.pop_front());
            void'(m_rc.pop_front());
        end
        if (halt || xfer_load) begin
            m_part.delete();
            if (xfer_load) begin
                m_rem = int'(cfg_xfer_len);
                m_err = 0;
            end else m_rem = 0;
        end else begin
            if (wr_valid) begin
                if (m_rem == 0 || tot == FD || (comp && qn == QD)) m_err = 1;
                else begin
                    m_part.push_back(int'(wr_data));
                    if (comp) begin
                        foreach (m_part[k]) m_dat.push_back(m_part[k]);
                        m_part.delete();
                        m_rb.push_back(pkt);
                        m_rc.push_back(int'(cfg_chan));
                        m_rem = m_rem - pkt;
                    end
                end
            end
            if (zlp_trig && rem0 == 0) begin
                if (qn == QD) m_err = 1;
                else begin
                    m_rb.push_back(0);
                    m_rc.push_back(int'(cfg_chan));
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        xfer_load = 0; halt = 0; wr_valid = 0; zlp_trig = 0;
        req_pop = 0; dat_pop = 0;
        compare_all();
    endtask

    task automatic load(input int len, input int mps, input int ch);
        cfg_xfer_len = XW'(len);
        cfg_mps = 11'(mps);
        cfg_chan = 4'(ch);
        xfer_load = 1;
        step();
    endtask

    task automatic wr(input int n);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1;
            wr_data = 32'(wcount * 32'h01010101 + 7);
            wcount++;
            step();
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && (m_rb.size() > 0 || m_dat.size() > 0); i++) begin
            req_pop = 1;
            dat_pop = 1;
            step();
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(int'(fifo_free), FD, "R1", "fifo_free");
        chk(int'(queue_free), QD, "R1", "queue_free");
        chk(int'(empty_irq), 1, "R1", "empty_irq");
        chk(int'(req_valid), 0, "R1", "req_valid");
        chk(int'(dat_valid), 0, "R1", "dat_valid");
        chk(int'(ovf_err), 0, "R1", "ovf_err");
        chk(int'(xfer_rem), 0, "R1", "xfer_rem");

        // R5/R2: 20 bytes at 8-byte packets -> 8, 8, 4
        load(20, 8, 3);
        wr(1);
        chk(int'(dat_valid), 0, "R2", "partial hidden");
        wr(4);
        drain();

        // R4: 10-byte packet padded to 3 words
        load(10, 16, 5);
        wr(3);
        chk(int'(req_bytes), 10, "R4", "padded count");
        drain();

        // R3: FIFO full (64-byte packet fills all 16 words)
        load(100, 64, 1);
        wr(17);
        chk(int'(ovf_err), 1, "R3", "fifo full reject");
        halt = 1; step();
        drain();

        // R3: queue full with 1-word packets
        load(40, 4, 2);
        wr(5);
        chk(int'(ovf_err), 1, "R3", "queue full reject");
        halt = 1; step();
        drain();

        // R9: halt in mid-packet
        load(32, 16, 7);
        wr(2);
        halt = 1; step();
        chk(int'(fifo_free), FD, "R9", "partial dropped");
        chk(int'(xfer_rem), 0, "R9", "rem cleared");
        wr(1); // R5: write with nothing left

        // R10: zero-length packet
        load(0, 8, 9);
        zlp_trig = 1; step();
        chk(int'(req_valid), 1, "R10", "zlp queued");
        chk(int'(req_bytes), 0, "R10", "zlp bytes");
        chk(int'(fifo_free), FD, "R10", "zlp no data");
        drain();
        load(8, 8, 1);
        zlp_trig = 1; step();
        chk(int'(queue_free), QD, "R10", "zlp ignored");

        // R8: pops with nothing valid
        halt = 1; step();
        req_pop = 1; dat_pop = 1; step();
        chk(int'(queue_free), QD, "R8", "idle pop");

        // mixed traffic: 12-byte packets, random writes and pops
        load(200, 12, 6);
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            wr_valid = lf[0] | lf[3];
            wr_data = 32'(wcount * 32'h00010003);
            wcount++;
            dat_pop = lf[1];
            req_pop = lf[2] & lf[5];
            step();
        end
        drain();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end
endmodule